// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block paces a multi-channel analog-to-digital conversion loop from a slow timing clock (nominally 32.768 kHz). It visits its channels in a fixed rotating order. For each one it raises a start pulse and a channel index towards an external converter. At the end of the channel's slot it takes the converter's result into that channel's result register, and a set number of clocks later it signals that the threshold comparators may refresh the channel's output.

There are two pacing styles. In continuous mode the slots follow one another with no gap. In interval mode one burst covering every channel begins at the start of each period, and the sequencer idles for the rest of the period. Three stop conditions behave differently. A software shutdown freezes the results. A software reset-mode and the active-low hardware stop pin both restore the results to all ones. The synchronous reset acts like the stop pin. Whenever pacing resumes, it starts again from channel 1 with a fresh slot.

Top module: `conv_sequencer`

## Requirements
- R1: Channels are visited in the order 1, 2, 3, 4 and then 1 again. The channel index on `adc_chan`, `res_chan` and `cmp_chan` is the channel number minus one, so channel 1 is 0 and channel 4 is 3.
- R2: In continuous mode (`cfg_interval`=0) each slot is SLOT_NORM clocks long (default 40) and slots run back to back. `adc_start` is high for one cycle at the first cycle of each slot, and `res_valid` is high for one cycle at the last cycle of each slot.
- R3: In interval mode (`cfg_interval`=1) each slot is SLOT_INTV clocks long (default 60). A burst of one slot per channel begins at the start of each period, and no `adc_start` appears after the burst until the next period begins.
- R4: `cfg_fast`=1 selects a period of PER_FAST clocks (default 32768, which is 1 s). `cfg_fast`=0 selects PER_SLOW clocks (default 131072, which is 4 s). The period is measured from one burst start to the next.
- R5: `cmp_update` pulses for one cycle exactly UPD_DLY clocks (default 10) after each `res_valid`, and `cmp_chan` carries the channel of that result.
- R6: On `res_valid`, `res_chan` and `res_data` carry the channel and the value of `adc_result` sampled in the slot's last cycle. The same value appears in that channel's byte of `res_regs` (channel n at bits n*DW upward) in that same cycle.
- R7: While `cfg_shutdown`=1 there is no `adc_start`, `res_valid` or `cmp_update`, and `res_regs` holds its contents.
- R8: While `cfg_reset`=1 there are no strobes, and every byte of `res_regs` reads all ones from the cycle after the first clock edge that sees it.
- R9: `stop_n`=0 and `rst`=1 each have the same effect as R8. After reset all strobes are low.
- R10: After every stop condition clears, `adc_start` rises with channel index 0 in the cycle after the first clock edge at which no stop condition is present.
- R11: A change of `cfg_interval` or `cfg_fast` takes one clock edge as a stop and then restarts the sequence as in R10. The result registers are held.
- R12: A stop condition cancels any pending `cmp_update`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Active-low hard stop and clear |
| cfg_shutdown | input | 1 | Freeze: stop pacing, hold results |
| cfg_reset | input | 1 | Reset mode: stop pacing, clear results |
| cfg_interval | input | 1 | 1 selects interval mode |
| cfg_fast | input | 1 | 1 selects the short interval period |
| adc_result | input | DW | Converter output value |
| adc_start | output | 1 | Start-of-conversion pulse |
| adc_chan | output | CW | Channel to convert |
| res_valid | output | 1 | Result capture strobe |
| res_chan | output | CW | Channel of the captured result |
| res_data | output | DW | Captured result value |
| cmp_update | output | 1 | Comparator refresh strobe |
| cmp_chan | output | CW | Channel to refresh |
| res_regs | output | NCH*DW | All channel results, channel 0 in the low byte |

## Verification
The bench keeps the default slot lengths of 40 and 60 clocks, the update delay of 10 and four 8-bit channels. It shortens the two interval periods to 300 and 700 clocks. With those periods, several full bursts of both lengths, together with the idle gaps between them, fit within a few thousand cycles, so the period counter wraps many times. A behavioural model derives every expected strobe from the number of running cycles since the last restart. Shutdown, reset mode, the stop pin, mode switches and an update cancelled in flight are each placed at points where the model's result differs from that of a design that lacks the feature.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef struct packed {
    logic interval;
    logic fast;
  } seq_mode_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer
  import conv_seq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int SLOT_NORM = 40,
  parameter int SLOT_INTV = 60,
  parameter int PER_FAST  = 32768,
  parameter int PER_SLOW  = 131072
) (
  input  logic                                clk,
  input  logic                                stop,
  input  seq_mode_t                           mode,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ch_o,
  output logic                                start_o,
  output logic                                done_o
);
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SLW = $clog2(max2(SLOT_NORM, SLOT_INTV) + 1);
  localparam int PW  = $clog2(max2(PER_FAST, PER_SLOW) + 1);
  localparam logic [CW-1:0] CH_LAST = CW'(NCH - 1);

  logic [SLW-1:0] cnt, slot_last;
  logic [PW-1:0]  pcnt, per_last;
  logic [CW-1:0]  ch;
  logic           busy;

  always_comb begin
    slot_last = mode.interval ? SLW'(SLOT_INTV - 1) : SLW'(SLOT_NORM - 1);
    per_last  = mode.fast ? PW'(PER_FAST - 1) : PW'(PER_SLOW - 1);
  end

  assign ch_o    = ch;
  assign start_o = !stop && busy && (cnt == '0);
  assign done_o  = !stop && busy && (cnt == slot_last);

  always_ff @(posedge clk) begin
    if (stop) begin
      cnt  <= '0;
      ch   <= '0;
      pcnt <= '0;
      busy <= 1'b1;
    end else begin
      if (busy) begin
        if (cnt == slot_last) begin
          cnt <= '0;
          if (ch == CH_LAST) begin
            ch <= '0;
            if (mode.interval) busy <= 1'b0;
          end else begin
            ch <= ch + CW'(1);
          end
        end else begin
          cnt <= cnt + SLW'(1);
        end
      end
      if (mode.interval) begin
        if (pcnt >= per_last) begin
          pcnt <= '0;
          busy <= 1'b1;
        end else begin
          pcnt <= pcnt + PW'(1);
        end
      end else begin
        pcnt <= '0;
      end
    end
  end

  // R1: after the last channel's slot the rotation returns to index 0
  assert_wrap_R1: assert property (@(posedge clk) disable iff (stop)
    (done_o && ch_o == CH_LAST) |=> (ch_o == '0));

  // R1: every other slot end advances to the next channel index
  assert_step_R1: assert property (@(posedge clk) disable iff (stop)
    (done_o && ch_o != CH_LAST) |=> (ch_o == CW'($past(ch_o) + 1'b1)));

endmodule

// File: rtl/upd_delay.sv
module upd_delay #(
  parameter int DLY = 10,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          stop,
  input  logic          fire,
  input  logic [CW-1:0] fire_ch,
  output logic          upd_o,
  output logic [CW-1:0] upd_ch_o
);
  localparam int DCW = $clog2(DLY + 1);

  logic [DCW-1:0] dcnt;
  logic [CW-1:0]  ch_q;

  assign upd_ch_o = ch_q;

  always_ff @(posedge clk) begin
    if (stop) begin
      dcnt  <= '0;
      upd_o <= 1'b0;
      ch_q  <= '0;
    end else begin
      upd_o <= (dcnt == DCW'(1));
      if (fire) begin
        dcnt <= DCW'(DLY);
        ch_q <= fire_ch;
      end else if (dcnt != '0) begin
        dcnt <= dcnt - DCW'(1);
      end
    end
  end

  // R5: a new result never arrives while an earlier update is still pending
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (stop)
    fire |-> (dcnt == '0));

endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int CW  = 2
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              we,
  input  logic [CW-1:0]     wch,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] regs_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [DW-1:0] val;
    always_ff @(posedge clk) begin
      if (clear)                         val <= '1;
      else if (we && wch == CW'(i))      val <= wdata;
    end
    assign regs_o[i*DW +: DW] = val;
  end

  // R7: without a write or a clear, every stored result is held
  assert_hold_R7: assert property (@(posedge clk) disable iff (clear)
    !we |=> $stable(regs_o));

  // R8: a clear leaves every channel at all ones
  assert_clear_R8: assert property (@(posedge clk)
    clear |=> (regs_o == '1));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 8,
  parameter int SLOT_NORM = 40,
  parameter int SLOT_INTV = 60,
  parameter int UPD_DLY   = 10,
  parameter int PER_FAST  = 32768,
  parameter int PER_SLOW  = 131072,
  localparam int CW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_n,
  input  logic              cfg_shutdown,
  input  logic              cfg_reset,
  input  logic              cfg_interval,
  input  logic              cfg_fast,
  input  logic [DW-1:0]     adc_result,
  output logic              adc_start,
  output logic [CW-1:0]     adc_chan,
  output logic              res_valid,
  output logic [CW-1:0]     res_chan,
  output logic [DW-1:0]     res_data,
  output logic              cmp_update,
  output logic [CW-1:0]     cmp_chan,
  output logic [NCH*DW-1:0] res_regs
);

  seq_mode_t     mode_cur, mode_q;
  logic          halt, stop;
  logic          start_c, done_c;
  logic [CW-1:0] ch;

  assign mode_cur = '{interval: cfg_interval, fast: cfg_fast};
  assign halt     = rst || !stop_n || cfg_reset;
  assign stop     = halt || cfg_shutdown || (mode_cur != mode_q);

  always_ff @(posedge clk) mode_q <= mode_cur;

  seq_timer #(
    .NCH(NCH), .SLOT_NORM(SLOT_NORM), .SLOT_INTV(SLOT_INTV),
    .PER_FAST(PER_FAST), .PER_SLOW(PER_SLOW)
  ) u_timer (
    .clk(clk), .stop(stop), .mode(mode_cur),
    .ch_o(ch), .start_o(start_c), .done_o(done_c)
  );

  upd_delay #(.DLY(UPD_DLY), .CW(CW)) u_upd (
    .clk(clk), .stop(stop), .fire(done_c), .fire_ch(ch),
    .upd_o(cmp_update), .upd_ch_o(cmp_chan)
  );

  result_bank #(.NCH(NCH), .DW(DW), .CW(CW)) u_bank (
    .clk(clk), .clear(halt), .we(done_c), .wch(ch),
    .wdata(adc_result), .regs_o(res_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_start <= 1'b0;
      adc_chan  <= '0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      adc_start <= start_c;
      adc_chan  <= ch;
      res_valid <= done_c;
      if (done_c) begin
        res_chan <= ch;
        res_data <= adc_result;
      end
    end
  end

  // R7: any stop silences every strobe on the next cycle
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!adc_start && !res_valid && !cmp_update));

  // R2: start is a single-cycle pulse
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  // R5: the delayed refresh never coincides with a capture
  assert_upd_apart_R5: assert property (@(posedge clk) disable iff (rst)
    cmp_update |-> !res_valid);

  // R10: leaving a stop begins again at channel index 0
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (!stop && $past(stop)) |=> (adc_start && adc_chan == '0));

endmodule

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb;
  localparam int NCH = 4, DW = 8, CW = 2;
  localparam int SN = 40, SI = 60, DLY = 10, PF = 300, PS = 700;

  logic clk = 0, rst = 1, stop_n = 1;
  logic cfg_shutdown = 0, cfg_reset = 0, cfg_interval = 0, cfg_fast = 0;
  logic [DW-1:0] adc_result = 0;
  logic adc_start, res_valid, cmp_update;
  logic [CW-1:0] adc_chan, res_chan, cmp_chan;
  logic [DW-1:0] res_data;
  logic [NCH*DW-1:0] res_regs;

  conv_sequencer #(.NCH(NCH), .DW(DW), .SLOT_NORM(SN), .SLOT_INTV(SI),
    .UPD_DLY(DLY), .PER_FAST(PF), .PER_SLOW(PS)) u_dut (
    .clk(clk), .rst(rst), .stop_n(stop_n), .cfg_shutdown(cfg_shutdown),
    .cfg_reset(cfg_reset), .cfg_interval(cfg_interval), .cfg_fast(cfg_fast),
    .adc_result(adc_result), .adc_start(adc_start), .adc_chan(adc_chan),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .cmp_update(cmp_update), .cmp_chan(cmp_chan), .res_regs(res_regs));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  string cur_req = "R9";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int t, pend, pend_ch;
  bit m_int, m_fast, started, m_fresh;
  bit exp_start, exp_we, exp_upd;
  int exp_chan, exp_wch, exp_wdata, exp_uch;
  logic [DW-1:0] er [NCH];

  always @(posedge clk) begin
    bit halt, stp, act;
    int slot, per, p, ph, chn;
    halt = rst || !stop_n || cfg_reset;
    stp  = halt || cfg_shutdown || (cfg_interval != m_int) || (cfg_fast != m_fast) || !started;
    m_int = cfg_interval; m_fast = cfg_fast; started = 1;
    exp_start = 0; exp_we = 0; exp_upd = 0;
    if (stp) begin
      t = 0; pend = -1;
      if (halt) for (int i = 0; i < NCH; i++) er[i] = '1;
    end else begin
      slot = cfg_interval ? SI : SN;
      p = t; act = 1;
      if (cfg_interval) begin
        per = cfg_fast ? PF : PS;
        p = t % per;
        if (p >= NCH * SI) act = 0;
      end
      ph = p % slot; chn = (p / slot) % NCH;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin exp_upd = 1; exp_uch = pend_ch; pend = -1; end
      end
      if (act && ph == 0) begin exp_start = 1; exp_chan = chn; m_fresh = (t == 0); end
      if (act && ph == slot - 1) begin
        exp_we = 1; exp_wch = chn; exp_wdata = adc_result;
        er[chn] = adc_result; pend = DLY; pend_ch = chn;
      end
      t++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(adc_start == exp_start, cfg_interval ? "R3" : "R2", "adc_start", adc_start, exp_start);
      if (adc_start && exp_start)
        chk(adc_chan == CW'(exp_chan), m_fresh ? "R10" : "R1", "adc_chan", adc_chan, exp_chan);
      chk(res_valid == exp_we, "R6", "res_valid", res_valid, exp_we);
      if (res_valid && exp_we) begin
        chk(res_chan == CW'(exp_wch), "R6", "res_chan", res_chan, exp_wch);
        chk(res_data == DW'(exp_wdata), "R6", "res_data", res_data, exp_wdata);
      end
      chk(cmp_update == exp_upd, "R5", "cmp_update", cmp_update, exp_upd);
      if (cmp_update && exp_upd)
        chk(cmp_chan == CW'(exp_uch), "R5", "cmp_chan", cmp_chan, exp_uch);
      for (int i = 0; i < NCH; i++)
        chk(res_regs[i*DW +: DW] == er[i], cur_req, "res_regs byte", res_regs[i*DW +: DW], er[i]);
    end
  end

  always @(negedge clk) adc_result <= DW'(cyc * 37 + 5);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++; checks++;
      $display("FAIL watchdog all actual=%0d expected=%0d", cyc, 60000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [NCH*DW-1:0] snap;
    int n;
    step(5);
    // R9: reset state
    chk(!adc_start && !res_valid && !cmp_update, "R9", "strobes after reset", adc_start, 0);
    chk(res_regs == '1, "R9", "regs after reset", 0, 1);
    rst = 0; cur_req = "R6";
    step(400);

    // R7: shutdown freezes
    cur_req = "R7"; snap = res_regs; cfg_shutdown = 1;
    step(100);
    chk(res_regs == snap, "R7", "regs held in shutdown", 0, 1);
    cfg_shutdown = 0; cur_req = "R10";
    step(200);

    // R8: reset mode clears
    cur_req = "R8"; cfg_reset = 1;
    step(20);
    chk(res_regs == '1, "R8", "regs all ones in reset mode", 0, 1);
    cfg_reset = 0;
    step(150);

    // R11, R3, R4: switch to interval fast and count bursts
    cur_req = "R11"; snap = res_regs; cfg_interval = 1; cfg_fast = 1; n = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(!adc_start, "R11", "no start on mode change edge", adc_start, 0);
        chk(res_regs == snap, "R11", "regs held on mode change", 0, 1);
      end
      if (i == 1) chk(adc_start && adc_chan == 0, "R11", "restart on channel 0", adc_chan, 0);
      if (adc_start && adc_chan == 0) n++;
    end
    chk(n == 5, "R4", "bursts in fast window", n, 5);
    cfg_fast = 0; n = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (adc_start && adc_chan == 0) n++;
    end
    chk(n == 3, "R4", "bursts in slow window", n, 3);

    // R12: stop cancels a pending update
    cfg_interval = 0; cur_req = "R12";
    step(3);
    while (!res_valid) @(negedge clk);
    cfg_shutdown = 1; step(2); cfg_shutdown = 0; n = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (cmp_update) n++;
    end
    chk(n == 0, "R12", "cancelled updates", n, 0);
    step(200);

    // R9: stop pin clears
    cur_req = "R9"; stop_n = 0;
    step(10);
    chk(res_regs == '1 && !adc_start, "R9", "regs cleared by stop pin", 0, 1);
    stop_n = 1;
    step(100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule